// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one DMA channel that moves buffers between memory locations or peripherals. It shares one memory master port between descriptor traffic and data beats. Software starts it in one of two ways. In direct mode it presents the source address, destination address and the two control words on input pins, and the channel moves exactly one buffer. In chained mode it presents a pointer to the first descriptor in memory. The channel then walks the list, and each buffer's descriptor says whether another one follows.

A descriptor is five consecutive 32-bit words: source address, destination address, next pointer, control word A and control word B. Control A sets the beat count, the source and destination widths and the chunk length. Control B sets the flow class, the fixed or incrementing address selects and the two "stop fetching" bits. When a buffer ends, the channel rewrites that buffer's control A in memory with a zero count and a set completion bit. It then goes straight on to the next descriptor. It does not wait for software to service the status. Three sticky status flags report buffer completion, chain completion and bus errors. The flags drive one interrupt line, and a read strobe clears them. Peripheral pacing is modelled by a single request input.

Top module: `dma_ll_engine`

## Requirements
- R1: After reset busy_o, irq_o, stat_o and mem_req_o are all low.
- R2: A chained start reads five words at desc+0, +4, +8, +12 and +16, in that order. They are loaded as source address, destination address, next pointer, control A and control B.
- R3: Control A bits [15:0] give the beat count in source-width units. Bits [17:16] give the source width and bits [19:18] the destination width, where 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. Each beat reads one source item from mem_rdata_i bits 0 upward, then writes it at the destination width, truncated or zero-extended. mem_size_o carries the width code.
- R4: Control B bit 2 holds the source address fixed and bit 3 holds the destination address fixed. Otherwise each address steps by its own width after every beat.
- R5: After each chained buffer, one write to desc+12 stores control A with bits [15:0] cleared and bit 31 set. All other bits are kept.
- R6: If control B bits 4 and 5 are not both set, the next descriptor is fetched from the next pointer at once, with no status read needed. If both are set, the channel stops after the write-back, busy_o drops and stat_o bit 1 is set.
- R7: A direct start moves one buffer from the pin values. It makes no descriptor reads and no write-back, and sets both stat_o bit 0 and stat_o bit 1.
- R8: A beat count of zero issues no data beats. In chained mode the write-back still takes place.
- R9: When control B bits [1:0] are nonzero, each chunk starts only when periph_req_i is high. A chunk is 4 beats if control A bit 20 is set, otherwise 1 beat. With code 0, periph_req_i is ignored.
- R10: stat_o holds error on bit 2, chain done on bit 1 and buffer done on bit 0. irq_o is the OR of these bits. A stat_rd_i cycle clears every flag that is not being set in that same cycle.
- R11: mem_err_i together with mem_ack_i on any access sets stat_o bit 2, drops busy_o and ends all further requests.
- R12: start_i has no effect while busy_o is high, and the port is silent while busy_o is low.
- R13: Once mem_req_o is raised, it stays high with a stable address and direction until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| multi_i | input | 1 | 1: chained mode, 0: direct mode |
| desc_ptr_i | input | ADDR_W | First descriptor address |
| dir_saddr_i | input | ADDR_W | Direct-mode source address |
| dir_daddr_i | input | ADDR_W | Direct-mode destination address |
| dir_ctrla_i | input | 32 | Direct-mode control A |
| dir_ctrlb_i | input | CB_W | Direct-mode control B, low bits |
| periph_req_i | input | 1 | Peripheral chunk request |
| stat_rd_i | input | 1 | Status read, clears flags |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_size_o | output | 2 | Width code of access |
| mem_wdata_o | output | 32 | Write data, low-justified |
| mem_ack_i | input | 1 | Access accepted this cycle |
| mem_err_i | input | 1 | Access failed, valid with ack |
| mem_rdata_i | input | 32 | Read data, low-justified |
| busy_o | output | 1 | Channel enabled |
| irq_o | output | 1 | Any status flag set |
| stat_o | output | 3 | Status flags {err, chain, buffer} |

## Verification
Several properties are checked on every cycle. The port holds a request until it is accepted, and it stays silent while the channel is idle. The fetch index steps one word per accepted read. Error and chain-end pulses disable the channel on the next cycle. A peripheral-paced chunk never starts without a request, and a status read clears the flags. Other behaviour can only be shown by the bench's scenarios, because it needs a memory image to compare against a reference model. This covers the byte-exact result of width conversion and fixed addresses, the write-back word contents, chain walking across descriptors, zero-count buffers, a start ignored while busy, and the beat count admitted by one peripheral request.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;
  typedef enum logic [2:0] {CS_IDLE, CS_FETCH, CS_LAUNCH, CS_XFER, CS_WBACK} ctl_state_e;
  typedef enum logic [1:0] {MV_IDLE, MV_WAIT, MV_RD, MV_WR} mv_state_e;

  localparam int CA_SW_LSB = 16;
  localparam int CA_DW_LSB = 18;
  localparam int CA_CH4    = 20;
  localparam int CA_DONE   = 31;
  localparam int CB_W      = 6;
  localparam int CB_SFIX   = 2;
  localparam int CB_DFIX   = 3;
  localparam int CB_SDIS   = 4;
  localparam int CB_DDIS   = 5;

  function automatic logic [2:0] beat_bytes(logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_ll_mover.sv
module dma_ll_mover
  import dma_ll_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] saddr_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        sw_i,
  input  logic [1:0]        dw_i,
  input  logic              ch4_i,
  input  logic [1:0]        flow_i,
  input  logic              sfix_i,
  input  logic              dfix_i,
  input  logic              periph_req_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        size_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic              fail_o
);
  mv_state_e         st_q;
  logic [ADDR_W-1:0] sa_q, da_q;
  logic [CNT_W-1:0]  left_q;
  logic [1:0]        cpos_q, cpos_nx;
  logic [DATA_W-1:0] data_q, rmask;
  logic [1:0]        sw_q, dw_q;
  logic              sfix_q, dfix_q, pflow_q, ch4_q, beat_end;

  assign cpos_nx  = ch4_q ? cpos_q + 2'd1 : 2'd0;
  assign beat_end = (st_q == MV_WR) && ack_i && !err_i;
  assign done_o   = beat_end && (left_q == CNT_W'(1));
  assign fail_o   = (st_q == MV_RD || st_q == MV_WR) && ack_i && err_i;
  assign req_o    = (st_q == MV_RD) || (st_q == MV_WR);
  assign we_o     = (st_q == MV_WR);
  assign addr_o   = we_o ? da_q : sa_q;
  assign size_o   = we_o ? dw_q : sw_q;
  assign wdata_o  = data_q;

  always_comb begin
    case (sw_q)
      2'd0:    rmask = DATA_W'(8'hFF);
      2'd1:    rmask = DATA_W'(16'hFFFF);
      default: rmask = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= MV_IDLE; sa_q <= '0; da_q <= '0; left_q <= '0; cpos_q <= '0;
      data_q <= '0; sw_q <= '0; dw_q <= '0;
      sfix_q <= 1'b0; dfix_q <= 1'b0; pflow_q <= 1'b0; ch4_q <= 1'b0;
    end else begin
      case (st_q)
        MV_IDLE: if (go_i) begin
          sa_q <= saddr_i; da_q <= daddr_i; left_q <= cnt_i; cpos_q <= '0;
          sw_q <= sw_i; dw_q <= dw_i; ch4_q <= ch4_i;
          sfix_q <= sfix_i; dfix_q <= dfix_i; pflow_q <= (flow_i != 2'd0);
          st_q <= (flow_i != 2'd0) ? MV_WAIT : MV_RD;
        end
        MV_WAIT: if (periph_req_i) st_q <= MV_RD;
        MV_RD: if (ack_i) begin
          if (err_i) st_q <= MV_IDLE;
          else begin
            data_q <= rdata_i & rmask;
            st_q   <= MV_WR;
          end
        end
        MV_WR: if (ack_i) begin
          if (err_i) st_q <= MV_IDLE;
          else begin
            if (!sfix_q) sa_q <= sa_q + ADDR_W'(beat_bytes(sw_q));
            if (!dfix_q) da_q <= da_q + ADDR_W'(beat_bytes(dw_q));
            left_q <= left_q - CNT_W'(1);
            cpos_q <= cpos_nx;
            if (left_q == CNT_W'(1))          st_q <= MV_IDLE;
            else if (pflow_q && cpos_nx == '0) st_q <= MV_WAIT;
            else                               st_q <= MV_RD;
          end
        end
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  AST_NO_UNPACED_CHUNK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MV_WAIT && !periph_req_i) |=> !req_o) else $error("paced chunk began"); // R9
endmodule

// File: rtl/dma_ll_ctrl.sv
module dma_ll_ctrl
  import dma_ll_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              multi_i,
  input  logic [ADDR_W-1:0] desc_ptr_i,
  input  logic [ADDR_W-1:0] dir_saddr_i,
  input  logic [ADDR_W-1:0] dir_daddr_i,
  input  logic [31:0]       dir_ctrla_i,
  input  logic [CB_W-1:0]   dir_ctrlb_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       wdata_o,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic [31:0]       rdata_i,
  output logic              mv_go_o,
  output logic [ADDR_W-1:0] saddr_o,
  output logic [ADDR_W-1:0] daddr_o,
  output logic [31:0]       ctrla_o,
  output logic [CB_W-1:0]   ctrlb_o,
  input  logic              mv_done_i,
  input  logic              mv_fail_i,
  output logic              buf_done_o,
  output logic              chain_done_o,
  output logic              fail_o,
  output logic              busy_o
);
  localparam logic [31:0] DONE_M = 32'h1 << CA_DONE;
  localparam logic [31:0] CNT_M  = (32'h1 << CNT_W) - 32'h1;

  ctl_state_e        st_q;
  logic              multi_q;
  logic [ADDR_W-1:0] cur_q, nxt_q, sa_q, da_q;
  logic [31:0]       ca_q;
  logic [CB_W-1:0]   cb_q;
  logic [2:0]        fidx_q;
  logic              last_buf, zero_cnt, fetch_ok, wb_ok, port_err, single_end;

  assign last_buf   = cb_q[CB_SDIS] & cb_q[CB_DDIS];
  assign zero_cnt   = (ca_q[CNT_W-1:0] == '0);
  assign fetch_ok   = (st_q == CS_FETCH) && ack_i && !err_i;
  assign wb_ok      = (st_q == CS_WBACK) && ack_i && !err_i;
  assign port_err   = (st_q == CS_FETCH || st_q == CS_WBACK) && ack_i && err_i;
  assign single_end = !multi_q && (((st_q == CS_LAUNCH) && zero_cnt) ||
                                   ((st_q == CS_XFER) && mv_done_i));

  assign buf_done_o   = wb_ok || single_end;
  assign chain_done_o = (wb_ok && last_buf) || single_end;
  assign fail_o       = port_err || ((st_q == CS_XFER) && mv_fail_i);
  assign busy_o       = (st_q != CS_IDLE);
  assign mv_go_o      = (st_q == CS_LAUNCH) && !zero_cnt;
  assign saddr_o      = sa_q;
  assign daddr_o      = da_q;
  assign ctrla_o      = ca_q;
  assign ctrlb_o      = cb_q;

  assign req_o   = (st_q == CS_FETCH) || (st_q == CS_WBACK);
  assign we_o    = (st_q == CS_WBACK);
  assign addr_o  = cur_q + ADDR_W'(we_o ? 5'd12 : {fidx_q, 2'b00});
  assign wdata_o = (ca_q | DONE_M) & ~CNT_M;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= CS_IDLE; multi_q <= 1'b0; cur_q <= '0; nxt_q <= '0;
      sa_q <= '0; da_q <= '0; ca_q <= '0; cb_q <= '0; fidx_q <= '0;
    end else begin
      case (st_q)
        CS_IDLE: if (start_i) begin
          multi_q <= multi_i;
          if (multi_i) begin
            cur_q  <= desc_ptr_i;
            fidx_q <= '0;
            st_q   <= CS_FETCH;
          end else begin
            sa_q <= dir_saddr_i;
            da_q <= dir_daddr_i;
            ca_q <= dir_ctrla_i & ~DONE_M;
            cb_q <= dir_ctrlb_i;
            st_q <= CS_LAUNCH;
          end
        end
        CS_FETCH: if (ack_i) begin
          if (err_i) st_q <= CS_IDLE;
          else begin
            case (fidx_q)
              3'd0:    sa_q  <= rdata_i[ADDR_W-1:0];
              3'd1:    da_q  <= rdata_i[ADDR_W-1:0];
              3'd2:    nxt_q <= rdata_i[ADDR_W-1:0];
              3'd3:    ca_q  <= rdata_i & ~DONE_M;
              default: cb_q  <= rdata_i[CB_W-1:0];
            endcase
            fidx_q <= fidx_q + 3'd1;
            if (fidx_q == 3'd4) st_q <= CS_LAUNCH;
          end
        end
        CS_LAUNCH: begin
          if (zero_cnt) st_q <= multi_q ? CS_WBACK : CS_IDLE;
          else          st_q <= CS_XFER;
        end
        CS_XFER: begin
          if (mv_fail_i)      st_q <= CS_IDLE;
          else if (mv_done_i) st_q <= multi_q ? CS_WBACK : CS_IDLE;
        end
        CS_WBACK: if (ack_i) begin
          if (err_i || last_buf) st_q <= CS_IDLE;
          else begin
            cur_q  <= nxt_q;
            fidx_q <= '0;
            st_q   <= CS_FETCH;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  AST_FETCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_ok && fidx_q != 3'd4) |=> (st_q == CS_FETCH && fidx_q == $past(fidx_q) + 3'd1))
    else $error("fetch order broken"); // R2
  AST_CHAIN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_done_o |=> !busy_o) else $error("busy after chain end"); // R6
  AST_FAIL_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !busy_o) else $error("busy after error"); // R11
endmodule

// File: rtl/dma_ll_status.sv
module dma_ll_status #(
  parameter int NFLAG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic             rd_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flag_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= set_i[g] | (flag_q[g] & ~rd_i);
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |flag_q;

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && set_i == '0) |=> (flags_o == '0)) else $error("flags survived read"); // R10
endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
  import dma_ll_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              multi_i,
  input  logic [ADDR_W-1:0] desc_ptr_i,
  input  logic [ADDR_W-1:0] dir_saddr_i,
  input  logic [ADDR_W-1:0] dir_daddr_i,
  input  logic [31:0]       dir_ctrla_i,
  input  logic [CB_W-1:0]   dir_ctrlb_i,
  input  logic              periph_req_i,
  input  logic              stat_rd_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic [2:0]        stat_o
);
  logic              c_req, c_we, m_req, m_we;
  logic [ADDR_W-1:0] c_addr, m_addr, sa, da;
  logic [31:0]       c_wdata, m_wdata, ca;
  logic [CB_W-1:0]   cb;
  logic [1:0]        m_size;
  logic              mv_go, mv_done, mv_fail, buf_done, chain_done, fail;

  dma_ll_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .multi_i, .desc_ptr_i, .dir_saddr_i, .dir_daddr_i,
    .dir_ctrla_i, .dir_ctrlb_i,
    .req_o(c_req), .we_o(c_we), .addr_o(c_addr), .wdata_o(c_wdata),
    .ack_i(mem_ack_i), .err_i(mem_err_i), .rdata_i(mem_rdata_i),
    .mv_go_o(mv_go), .saddr_o(sa), .daddr_o(da), .ctrla_o(ca), .ctrlb_o(cb),
    .mv_done_i(mv_done), .mv_fail_i(mv_fail),
    .buf_done_o(buf_done), .chain_done_o(chain_done), .fail_o(fail), .busy_o(busy_o)
  );

  dma_ll_mover #(.ADDR_W(ADDR_W), .DATA_W(32), .CNT_W(CNT_W)) u_mover (
    .clk_i, .rst_ni, .go_i(mv_go), .saddr_i(sa), .daddr_i(da),
    .cnt_i(ca[CNT_W-1:0]), .sw_i(ca[CA_SW_LSB+:2]), .dw_i(ca[CA_DW_LSB+:2]),
    .ch4_i(ca[CA_CH4]), .flow_i(cb[1:0]), .sfix_i(cb[CB_SFIX]), .dfix_i(cb[CB_DFIX]),
    .periph_req_i,
    .req_o(m_req), .we_o(m_we), .addr_o(m_addr), .size_o(m_size), .wdata_o(m_wdata),
    .ack_i(mem_ack_i), .err_i(mem_err_i), .rdata_i(mem_rdata_i),
    .done_o(mv_done), .fail_o(mv_fail)
  );

  dma_ll_status #(.NFLAG(3)) u_stat (
    .clk_i, .rst_ni, .set_i({fail, chain_done, buf_done}), .rd_i(stat_rd_i),
    .flags_o(stat_o), .irq_o(irq_o)
  );

  assign mem_req_o   = c_req | m_req;
  assign mem_we_o    = c_req ? c_we    : m_we;
  assign mem_addr_o  = c_req ? c_addr  : m_addr;
  assign mem_wdata_o = c_req ? c_wdata : m_wdata;
  assign mem_size_o  = c_req ? 2'd2    : m_size;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)))
    else $error("request dropped or moved"); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o) else $error("access while idle"); // R12
  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_req && m_req)) else $error("port contention"); // R13
endmodule

// File: tb/dma_ll_engine_bench.sv
module dma_ll_engine_bench;
  localparam int AW = 32;

  logic clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  logic          rst_ni = 1'b0, start_i = 1'b0, multi_i = 1'b0, periph_req_i = 1'b0, stat_rd_i = 1'b0;
  logic [AW-1:0] desc_ptr_i = '0, dir_saddr_i = '0, dir_daddr_i = '0;
  logic [31:0]   dir_ctrla_i = '0;
  logic [5:0]    dir_ctrlb_i = '0;
  logic          mem_req_o, mem_we_o, mem_ack_i, mem_err_i, busy_o, irq_o;
  logic [AW-1:0] mem_addr_o;
  logic [1:0]    mem_size_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i;
  logic [2:0]    stat_o;

  dma_ll_engine u_dma_ll_engine (.*);

  logic [7:0] mem  [0:1023];
  logic [7:0] rmem [0:1023];
  logic       stall = 1'b0, err_en = 1'b0;
  logic [9:0] err_a = '0, ma;
  int         log_n = 0, hold_bad = 0, n_tests = 0, n_fail = 0;
  logic [9:0] log_a [0:2047];
  logic       log_w [0:2047];
  logic       prev_pend = 1'b0;
  logic [AW-1:0] prev_a = '0;

  assign ma          = mem_addr_o[9:0];
  assign mem_rdata_i = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};
  assign mem_ack_i   = mem_req_o & ~stall;
  assign mem_err_i   = mem_ack_i & err_en & (ma == err_a);

  always @(posedge clk_i) begin
    if (prev_pend && !(mem_req_o && mem_addr_o == prev_a)) hold_bad++;
    prev_pend = mem_req_o && !mem_ack_i;
    prev_a    = mem_addr_o;
    if (mem_req_o && mem_ack_i) begin
      if (log_n < 2048) begin log_a[log_n] = ma; log_w[log_n] = mem_we_o; end
      log_n++;
      if (mem_we_o && !mem_err_i)
        for (int b = 0; b < (mem_size_o == 2'd0 ? 1 : mem_size_o == 2'd1 ? 2 : 4); b++)
          mem[ma + 10'(b)] = mem_wdata_o[8*b +: 8];
    end
    stall <= ($urandom_range(0, 3) == 0);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bw(logic [1:0] c);
    return c == 2'd0 ? 1 : c == 2'd1 ? 2 : 4;
  endfunction

  function automatic logic [31:0] mk_ca(int cnt, int sw, int dw, bit ch4, bit done);
    return {done, 10'b0, ch4, 2'(dw), 2'(sw), 16'(cnt)};
  endfunction

  function automatic logic [31:0] mk_cb(int flow, bit sfix, bit dfix, bit last);
    return {26'b0, last, last, dfix, sfix, 2'(flow)};
  endfunction

  task automatic poke(int a, logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      mem[(a + b) & 1023]  = w[8*b +: 8];
      rmem[(a + b) & 1023] = w[8*b +: 8];
    end
  endtask

  task automatic put_desc(int a, int s, int d, int nx, logic [31:0] ca, logic [31:0] cb);
    poke(a, s); poke(a + 4, d); poke(a + 8, nx); poke(a + 12, ca); poke(a + 16, cb);
  endtask

  task automatic ref_move(int s, int d, logic [31:0] ca, logic [31:0] cb);
    int sw, dw;
    logic [31:0] v;
    sw = bw(ca[17:16]); dw = bw(ca[19:18]);
    for (int i = 0; i < int'(ca[15:0]); i++) begin
      v = '0;
      for (int b = 0; b < sw; b++) v[8*b +: 8] = rmem[(s + b) & 1023];
      for (int b = 0; b < dw; b++) rmem[(d + b) & 1023] = v[8*b +: 8];
      if (!cb[2]) s += sw;
      if (!cb[3]) d += dw;
    end
  endtask

  task automatic ref_wb(int a, logic [31:0] ca);
    logic [31:0] w;
    w = {1'b1, ca[30:16], 16'h0};
    for (int b = 0; b < 4; b++) rmem[(a + 12 + b) & 1023] = w[8*b +: 8];
  endtask

  task automatic cmp_mem(string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== rmem[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic go(bit multi, int ptr, int s, int d, logic [31:0] ca, logic [31:0] cb);
    @(negedge clk_i);
    multi_i = multi; desc_ptr_i = ptr; dir_saddr_i = s; dir_daddr_i = d;
    dir_ctrla_i = ca; dir_ctrlb_i = cb[5:0]; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy_o; i++) @(negedge clk_i);
  endtask

  task automatic read_stat(output logic [2:0] v);
    @(negedge clk_i);
    v = stat_o; stat_rd_i = 1'b1;
    @(negedge clk_i);
    stat_rd_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=idle");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] st;
    logic [31:0] ca, cb;
    int bad, s, d, n;
    void'($urandom(32'd2718));
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = (i >= 'h100 && i < 'h200) ? 8'($urandom) : 8'h00;
      rmem[i] = mem[i];
    end
    repeat (4) @(negedge clk_i);
    chk("R1 busy in reset", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 stat", stat_o, 0);
    chk("R1 mem_req", mem_req_o, 0);

    // Directed chain of three, mixed widths
    put_desc('h00, 'h100, 'h200, 'h20, mk_ca(4, 2, 2, 0, 1), mk_cb(0, 0, 0, 0));
    put_desc('h20, 'h120, 'h240, 'h40, mk_ca(3, 1, 0, 0, 0), mk_cb(0, 0, 0, 0));
    put_desc('h40, 'h130, 'h260, 'h00, mk_ca(2, 0, 2, 1, 0), mk_cb(0, 0, 0, 1));
    ref_move('h100, 'h200, mk_ca(4, 2, 2, 0, 1), 0); ref_wb('h00, mk_ca(4, 2, 2, 0, 1));
    ref_move('h120, 'h240, mk_ca(3, 1, 0, 0, 0), 0); ref_wb('h20, mk_ca(3, 1, 0, 0, 0));
    ref_move('h130, 'h260, mk_ca(2, 0, 2, 1, 0), 0); ref_wb('h40, mk_ca(2, 0, 2, 1, 0));
    log_n = 0;
    go(1, 'h00, 0, 0, 0, 0);
    wait_idle();
    bad = 0;
    for (int i = 0; i < 5; i++) if (log_a[i] != 10'(4*i) || log_w[i]) bad++;
    chk("R2 fetch order", bad, 0);
    chk("R6 busy after last", busy_o, 0);
    cmp_mem("R3 R5 chain image");
    chk("R10 irq pending", irq_o, 1);
    read_stat(st);
    chk("R6 stat chain", st, 3'b011);
    chk("R10 stat cleared", stat_o, 0);
    chk("R10 irq cleared", irq_o, 0);

    // Random direct buffers
    for (int t = 0; t < 20; t++) begin
      ca = mk_ca($urandom_range(1, 16), $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 1), 0);
      cb = mk_cb(0, $urandom_range(0, 1), $urandom_range(0, 1), 0);
      s = 'h100 + $urandom_range(0, 'hB0); d = 'h200 + $urandom_range(0, 'h100);
      ref_move(s, d, ca, cb);
      log_n = 0;
      go(0, 0, s, d, ca, cb);
      wait_idle();
      bad = 0;
      for (int i = 0; i < log_n; i++) if (log_a[i] < 10'h100) bad++;
      chk("R7 no descriptor traffic", bad, 0);
      read_stat(st);
      chk("R7 direct flags", st, 3'b011);
    end
    cmp_mem("R3 R4 R9 direct image, periph_req_i low");

    // Random chains
    for (int t = 0; t < 10; t++) begin
      n = $urandom_range(1, 3);
      for (int k = 0; k < n; k++) begin
        ca = mk_ca($urandom_range(1, 16), $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 1), $urandom_range(0, 1));
        cb = mk_cb(0, $urandom_range(0, 1), $urandom_range(0, 1), k == n - 1);
        s = 'h100 + k * 'h50 + $urandom_range(0, 15);
        d = 'h200 + k * 'h60 + $urandom_range(0, 15);
        put_desc('h20 * k, s, d, 'h20 * (k + 1), ca, cb);
        ref_move(s, d, ca, cb);
        ref_wb('h20 * k, ca);
      end
      go(1, 'h00, 0, 0, 0, 0);
      wait_idle();
      read_stat(st);
      chk("R6 chain flags", st, 3'b011);
    end
    cmp_mem("R4 R5 R6 chain image");

    // Zero-count descriptor
    ca = mk_ca(0, 2, 2, 0, 0);
    put_desc('h60, 'h100, 'h300, 0, ca, mk_cb(0, 0, 0, 1));
    ref_wb('h60, ca);
    log_n = 0;
    go(1, 'h60, 0, 0, 0, 0);
    wait_idle();
    chk("R8 access count", log_n, 6);
    chk("R8 writeback addr", {22'b0, log_a[5]}, 'h6C);
    cmp_mem("R8 R5 zero image");
    read_stat(st);

    // Peripheral pacing, 4-beat chunks
    ca = mk_ca(8, 2, 2, 1, 0); cb = mk_cb(1, 0, 0, 1);
    ref_move('h140, 'h380, ca, cb);
    log_n = 0;
    go(0, 0, 'h140, 'h380, ca, cb);
    repeat (30) @(negedge clk_i);
    chk("R9 no beat before request", log_n, 0);
    chk("R9 still busy", busy_o, 1);
    periph_req_i = 1'b1;
    @(negedge clk_i);
    periph_req_i = 1'b0;
    repeat (60) @(negedge clk_i);
    bad = 0;
    for (int i = 0; i < log_n; i++) if (log_w[i]) bad++;
    chk("R9 one chunk of writes", bad, 4);
    periph_req_i = 1'b1;
    wait_idle();
    periph_req_i = 1'b0;
    cmp_mem("R9 paced image");
    read_stat(st);

    // Start while busy
    put_desc('h80, 'h100, 'h3C0, 0, mk_ca(4, 2, 2, 0, 0), mk_cb(0, 0, 0, 1));
    ca = mk_ca(16, 0, 0, 0, 0);
    put_desc('h00, 'h150, 'h300, 0, ca, mk_cb(0, 0, 0, 1));
    ref_move('h150, 'h300, ca, 0); ref_wb('h00, ca);
    log_n = 0;
    go(1, 'h00, 0, 0, 0, 0);
    @(negedge clk_i);
    go(1, 'h80, 0, 0, 0, 0);
    wait_idle();
    bad = 0;
    for (int i = 0; i < log_n; i++) if (log_a[i] >= 10'h80 && log_a[i] < 10'h94) bad++;
    chk("R12 second start ignored", bad, 0);
    cmp_mem("R12 image");
    read_stat(st);

    // Bus error during fetch
    err_en = 1'b1; err_a = 10'h0A8;
    log_n = 0;
    go(1, 'hA0, 0, 0, 0, 0);
    repeat (40) @(negedge clk_i);
    chk("R11 busy after error", busy_o, 0);
    chk("R11 accesses", log_n, 3);
    read_stat(st);
    chk("R11 error flag", st, 3'b100);
    err_en = 1'b0;

    chk("R13 request held until ack", hold_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule